// File: doc/BRIEF.md
# Double-Buffered Serial Shift Slice

This block is one serial shift lane built around a word-wide working register. A free-running shift-clock enable drives two nested reloadable down counters. The inner counter sets how many enabled cycles pass between single-bit shifts of the working register. The outer counter sets how many shifts happen between exchanges. On each exchange, the working register and a shadow register swap contents on the same clock edge. Software can therefore fill the shadow with the next word while the current word is still streaming, and it can collect the word that was just assembled.

The serial stream is paced only by the counters: one bit enters and one bit leaves on each shift event. It carries no valid/ready handshake and cannot be back-pressured. A consumer that needs the data must keep up with the exchange rate, which is the inner period times the outer period. Register access uses a plain write strobe with a select code and a combinational read port.

Top module: `shift_slice`

## Requirements
- R1: After reset the data, shadow, preset, count and position registers read zero, the slice is disabled, `sdo` is 0 and `xchg_pulse` is 0.
- R2: While the slice is enabled and `shift_en` is high (a tick), the count register (select 3) decrements by one; a tick that finds it at zero loads the preset register (select 2) instead, so a shift happens every preset+1 ticks.
- R3: A tick that finds the count at zero is a reload event. Each reload event decrements the position value (select 4, bits 7:0). A reload event that finds the position at zero loads it from the position-reset value (select 4, bits 15:8).
- R4: On a reload event the data register (select 0) shifts right by one, `sdi` enters at the MSB, and `sdo` always shows bit 0 of the data register.
- R5: On a reload event that finds the position at zero, the data register takes the old shadow (select 1), and the shadow takes the right-shifted data word, on the same edge.
- R6: `xchg_pulse` is high for the cycle after each edge on which an exchange happened, and low otherwise.
- R7: Select 5 bit 0 is a sticky flag that is set by an exchange. Writing select 5 with bit 0 set clears it. If an exchange and a clear fall in the same cycle, the set wins. Select 5 bit 1 reads back the enable state.
- R8: A register write to select 0, 1, 3 or 4 in the same cycle as a shift, swap or count update takes priority for the written register.
- R9: `en_set` enables the slice and `en_clr` disables it; when both are high, disable wins. While the slice is disabled, count, position, data and shadow change only through writes.
- R10: With a preset of zero, every tick is a reload event, so the slice shifts once per enabled `shift_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Shift-clock enable, one per shift-clock cycle |
| en_set | input | 1 | Strobe that enables counting |
| en_clr | input | 1 | Strobe that disables counting (wins over en_set) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 data, 1 shadow, 2 preset, 3 count, 4 position, 5 status |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read data |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output (data register bit 0) |
| xchg_pulse | output | 1 | One-cycle exchange indication |

## Verification
A count register that is off by one shifts the whole shift cadence. Within one preset period this shows as an `sdo` transition in the wrong cycle, and it shows at once on the count readback. A wrong position or position-reset value moves the exchange: `xchg_pulse` and the sticky flag appear on the wrong reload event, and the data and shadow readbacks disagree by a full word from that cycle on. A swap that takes its value before or after the shift, instead of the shifted word, leaves the shadow one bit off, and this is visible on the first read after the first exchange.

// File: rtl/shift_slice_pkg.sv
package shift_slice_pkg;
  typedef enum logic [2:0] {
    SEL_DATA   = 3'd0,
    SEL_SHADOW = 3'd1,
    SEL_PRESET = 3'd2,
    SEL_COUNT  = 3'd3,
    SEL_POS    = 3'd4,
    SEL_STAT   = 3'd5
  } reg_sel_e;

  localparam int unsigned NUM_SEL = 6;
  localparam int unsigned STAT_STICKY_BIT = 0;
  localparam int unsigned STAT_EN_BIT = 1;
endpackage

// File: rtl/shift_slice_timer.sv
module shift_slice_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_preset,
  input  logic             wr_count,
  input  logic             wr_pos,
  input  logic [CNT_W-1:0] wr_cnt_val,
  input  logic [2*POS_W-1:0] wr_pos_val,
  output logic [CNT_W-1:0] preset_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] prst_q,
  output logic             reload_evt,
  output logic             xchg_evt
);
  // inner divider: reload event when a tick meets an empty count
  assign reload_evt = tick && (cnt_q == '0);
  // outer divider: exchange when a reload event meets an empty position
  assign xchg_evt   = reload_evt && (pos_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset_q <= '0;
    end else if (wr_preset) begin
      preset_q <= wr_cnt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_count) begin
      cnt_q <= wr_cnt_val;
    end else if (tick) begin
      cnt_q <= reload_evt ? preset_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      prst_q <= '0;
    end else if (wr_pos) begin
      pos_q  <= wr_pos_val[POS_W-1:0];
      prst_q <= wr_pos_val[2*POS_W-1:POS_W];
    end else if (reload_evt) begin
      pos_q  <= xchg_evt ? prst_q : pos_q - 1'b1;
    end
  end
endmodule

// File: rtl/shift_slice_store.sv
module shift_slice_store #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_evt,
  input  logic          xchg_evt,
  input  logic          sdi,
  input  logic          wr_live,
  input  logic          wr_shadow,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] shadow_q
);
  logic [DW-1:0] shifted;
  assign shifted = {sdi, data_q[DW-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_live) begin
      data_q <= wr_val;
    end else if (reload_evt) begin
      data_q <= xchg_evt ? shadow_q : shifted;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr_shadow) begin
      shadow_q <= wr_val;
    end else if (xchg_evt) begin
      shadow_q <= shifted;
    end
  end
endmodule

// File: rtl/shift_slice_ctrl.sv
module shift_slice_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic xchg_evt,
  input  logic sticky_clr,
  output logic en_q,
  output logic sticky_q,
  output logic pulse_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sticky_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      if (en_clr)      en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;
      if (xchg_evt)        sticky_q <= 1'b1;
      else if (sticky_clr) sticky_q <= 1'b0;
      pulse_q <= xchg_evt;
    end
  end
endmodule

// File: rtl/shift_slice.sv
module shift_slice
  import shift_slice_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned POS_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          sdi,
  output logic          sdo,
  output logic          xchg_pulse
);
  localparam int unsigned PW2 = 2 * POS_W;

  logic [NUM_SEL-1:0] wr_hit;
  logic               tick;
  logic               reload_evt, xchg_evt;
  logic [CNT_W-1:0]   preset_q, cnt_q;
  logic [POS_W-1:0]   pos_q, prst_q;
  logic [DW-1:0]      data_q, shadow_q;
  logic               en_q, sticky_q, pulse_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_sel == 3'(g));
  end

  assign tick = en_q && shift_en;

  shift_slice_timer #(.CNT_W(CNT_W), .POS_W(POS_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_preset  (wr_hit[SEL_PRESET]),
    .wr_count   (wr_hit[SEL_COUNT]),
    .wr_pos     (wr_hit[SEL_POS]),
    .wr_cnt_val (wr_data[CNT_W-1:0]),
    .wr_pos_val (wr_data[PW2-1:0]),
    .preset_q   (preset_q),
    .cnt_q      (cnt_q),
    .pos_q      (pos_q),
    .prst_q     (prst_q),
    .reload_evt (reload_evt),
    .xchg_evt   (xchg_evt)
  );

  shift_slice_store #(.DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_evt (reload_evt),
    .xchg_evt   (xchg_evt),
    .sdi        (sdi),
    .wr_live    (wr_hit[SEL_DATA]),
    .wr_shadow  (wr_hit[SEL_SHADOW]),
    .wr_val     (wr_data),
    .data_q     (data_q),
    .shadow_q   (shadow_q)
  );

  shift_slice_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .xchg_evt   (xchg_evt),
    .sticky_clr (wr_hit[SEL_STAT] && wr_data[STAT_STICKY_BIT]),
    .en_q       (en_q),
    .sticky_q   (sticky_q),
    .pulse_q    (pulse_q)
  );

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_sel))
      SEL_DATA:   rd_data = data_q;
      SEL_SHADOW: rd_data = shadow_q;
      SEL_PRESET: rd_data = DW'(preset_q);
      SEL_COUNT:  rd_data = DW'(cnt_q);
      SEL_POS:    rd_data = DW'({prst_q, pos_q});
      SEL_STAT: begin
        rd_data[STAT_STICKY_BIT] = sticky_q;
        rd_data[STAT_EN_BIT]     = en_q;
      end
      default:    rd_data = '0;
    endcase
  end

  assign sdo        = data_q[0];
  assign xchg_pulse = pulse_q;
endmodule

// File: rtl/shift_slice_chk.sv
module shift_slice_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned POS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic             sdi,
  input logic             xchg_pulse,
  input logic             en_q,
  input logic             sticky_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] preset_q,
  input logic [POS_W-1:0] pos_q,
  input logic [DW-1:0]    data_q,
  input logic [DW-1:0]    shadow_q
);
  logic no_wr_cnt, no_wr_data, tick;
  assign no_wr_cnt  = !(wr_en && wr_sel == 3'd3);
  assign no_wr_data = !(wr_en && wr_sel == 3'd0);
  assign tick       = en_q && shift_en;

  p_count_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && no_wr_cnt) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_count_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && no_wr_cnt) |=> cnt_q == $past(preset_q));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && pos_q != '0 && no_wr_data)
      |=> data_q == {$past(sdi), $past(data_q[DW-1:1])});

  p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && pos_q == '0 && no_wr_data)
      |=> data_q == $past(shadow_q));

  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_pulse |-> $past(tick));

  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_pulse |-> sticky_q);

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> ($stable(cnt_q) && $stable(data_q) && $stable(pos_q)));
endmodule

bind shift_slice shift_slice_chk #(.DW(DW), .CNT_W(CNT_W), .POS_W(POS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_en   (shift_en),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .sdi        (sdi),
  .xchg_pulse (xchg_pulse),
  .en_q       (en_q),
  .sticky_q   (sticky_q),
  .cnt_q      (cnt_q),
  .preset_q   (preset_q),
  .pos_q      (pos_q),
  .data_q     (data_q),
  .shadow_q   (shadow_q)
);

// File: tb/shift_slice_bench.sv
`timescale 1ns/100ps
module shift_slice_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shift_en = 1'b0, en_set = 1'b0, en_clr = 1'b0, wr_en = 1'b0, sdi = 1'b0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        sdo, xchg_pulse;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_data, m_sh;
  logic [15:0] m_pre, m_cnt;
  logic [7:0]  m_pos, m_prst;
  logic        m_en, m_stk, m_pulse;

  always #2 clk = ~clk;

  shift_slice u_shift_slice (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .en_set(en_set), .en_clr(en_clr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .sdi(sdi), .sdo(sdo), .xchg_pulse(xchg_pulse)
  );

  function automatic logic [31:0] exp_rd(int s);
    case (s)
      0: return m_data;
      1: return m_sh;
      2: return {16'h0, m_pre};
      3: return {16'h0, m_cnt};
      4: return {16'h0, m_prst, m_pos};
      5: return {30'h0, m_en, m_stk};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string sel_tag(int s);
    case (s)
      0: return "R4";
      1: return "R5";
      2: return "R8";
      3: return "R2";
      4: return "R3";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    for (int s = 0; s < 6; s++) begin
      rd_sel = 3'(s);
      #0.2;
      chk(tag == "" ? sel_tag(s) : tag, rd_data, exp_rd(s));
    end
    chk("R4", {31'h0, sdo}, {31'h0, m_data[0]});
    chk("R6", {31'h0, xchg_pulse}, {31'h0, m_pulse});
  endtask

  task automatic model_reset();
    m_data = '0; m_sh = '0; m_pre = '0; m_cnt = '0; m_pos = '0; m_prst = '0;
    m_en = 0; m_stk = 0; m_pulse = 0;
  endtask

  // one clock: drive inputs, advance the model, compare after the edge
  task automatic step(bit sh, bit we, logic [2:0] ws, logic [31:0] wd,
                      bit es, bit ds, bit din, string tag);
    logic tick, rl, xc;
    logic [31:0] shifted, n_data, n_sh;
    logic [15:0] n_pre, n_cnt;
    logic [7:0]  n_pos, n_prst;
    shift_en = sh; wr_en = we; wr_sel = ws; wr_data = wd;
    en_set = es; en_clr = ds; sdi = din;
    tick = m_en && sh;
    rl = tick && (m_cnt == 16'h0);
    xc = rl && (m_pos == 8'h0);
    shifted = {din, m_data[31:1]};
    n_data = rl ? (xc ? m_sh : shifted) : m_data;
    n_sh = xc ? shifted : m_sh;
    n_pre = m_pre;
    n_cnt = tick ? ((m_cnt == 16'h0) ? m_pre : m_cnt - 16'h1) : m_cnt;
    n_pos = rl ? ((m_pos == 8'h0) ? m_prst : m_pos - 8'h1) : m_pos;
    n_prst = m_prst;
    if (we) begin
      case (ws)
        3'd0: n_data = wd;
        3'd1: n_sh = wd;
        3'd2: n_pre = wd[15:0];
        3'd3: n_cnt = wd[15:0];
        3'd4: begin n_pos = wd[7:0]; n_prst = wd[15:8]; end
        default: ;
      endcase
    end
    if (xc) m_stk = 1'b1;
    else if (we && ws == 3'd5 && wd[0]) m_stk = 1'b0;
    m_en = ds ? 1'b0 : (es ? 1'b1 : m_en);
    m_pulse = xc;
    m_data = n_data; m_sh = n_sh; m_pre = n_pre; m_cnt = n_cnt;
    m_pos = n_pos; m_prst = n_prst;
    @(posedge clk);
    @(negedge clk);
    shift_en = 0; wr_en = 0; en_set = 0; en_clr = 0;
    check_all(tag);
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d, string tag);
    step(1'b0, 1'b1, s, d, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // directed: preset 2, position 1 / reset 1, known words
    wr(3'd0, 32'hA5A5_0F0F, "R4");
    wr(3'd1, 32'h1234_5678, "R5");
    wr(3'd2, 32'h0000_0002, "R2");
    wr(3'd4, 32'h0000_0101, "R3");
    step(0, 0, 0, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, 0, i[0], "");

    // R10: preset zero shifts every tick
    wr(3'd2, 32'h0, "R10");
    wr(3'd3, 32'h0, "R10");
    wr(3'd4, 32'h0000_0300, "R10");
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, 0, i[1], "R10");

    // R8: writes collide with an exchange edge
    wr(3'd4, 32'h0000_0200, "R8");
    wr(3'd1, 32'hCAFE_F00D, "R8");
    step(1, 1, 3'd0, 32'h0BAD_BEEF, 0, 0, 1, "R8");
    wr(3'd4, 32'h0000_0000, "R8");
    step(1, 1, 3'd1, 32'h5555_AAAA, 0, 0, 0, "R8");

    // R7: clear and set in the same cycle, then a clean clear
    wr(3'd4, 32'h0000_0000, "R7");
    step(1, 1, 3'd5, 32'h1, 0, 0, 0, "R7");
    wr(3'd5, 32'h1, "R7");

    // R9: both strobes -> disabled, then ticks have no effect
    step(0, 0, 0, 0, 1, 1, 0, "R9");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 1, 0, 0, "R9");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit we, es, ds;
      logic [2:0] ws;
      logic [31:0] wd;
      we = ($urandom % 10) == 0;
      ws = 3'($urandom % 6);
      wd = $urandom;
      if (ws == 3'd2 || ws == 3'd3) wd = wd % 4;
      if (ws == 3'd4) wd = {16'h0, 6'h0, wd[9:8], 6'h0, wd[1:0]};
      es = ($urandom % 20) == 0;
      ds = ($urandom % 60) == 0;
      step(($urandom % 10) < 7, we, ws, wd, es, ds, $urandom % 2, "");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule